// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reset causes into one system reset for a small controller core. The four causes are a supply monitor that flags power-up or brownout, a watchdog timeout request, a software-issued internal request and an external active-low reset pin. The supply monitor acts as an asynchronous clear: while it reports a low supply, the block is in reset at once. Once the supply is good, the block counts a fixed oscillator start-up interval before it lets the core run. Any other cause holds the core in reset for as long as the request lasts, plus a short fixed tail.

The board-level reset line is open-drain and bidirectional. It is modelled as a sampled input (`pin_in`) and a pull-low enable (`pin_drive`). The enable is asserted only when the block itself generated the reset. The pin input path ignores the line while the block is pulling it, so the block never re-triggers on its own pulse.

Sticky one-hot cause flags tell boot software why the last reset happened. A single-cycle strobe clears them. The restart vector presented to the core is a constant, 8000h by default, whatever the cause.

Top module: `rst_sequencer`

## Requirements
- R1: While `bo_low` is 1, `sys_rst` and `pin_drive` are 1 and `cause_flags` is 4'b0001 (bit 0 = supply cause), without waiting for a clock edge.
- R2: After `bo_low` falls, `sys_rst` stays 1 for exactly STARTUP_CYCLES (default 1000) rising edges and is 0 after the last one. A new assertion of `bo_low` during the count restarts the count from zero.
- R3: `wdt_req` seen at a rising edge while running puts the block in reset at that edge, with `pin_drive` 1 and `cause_flags` 4'b0010 (bit 1 = watchdog).
- R4: `sw_req` seen at a rising edge while running puts the block in reset at that edge, with `pin_drive` 1 and `cause_flags` 4'b1000 (bit 3 = internal request).
- R5: `pin_in` held low is detected after two synchroniser stages and two consecutive low samples, so reset rises on the 4th rising edge after the pin falls. `cause_flags` becomes 4'b0100 (bit 2 = external), and `pin_drive` stays 0 throughout this reset.
- R6: `pin_in` low for only one rising edge causes no reset and leaves `cause_flags` unchanged.
- R7: After a watchdog or internal request drops, reset is released on the HOLD_CYCLES-th (default 16) rising edge counted from the first edge that samples the request low. For the pin, that first edge is two edges after the pin rises, because of the synchroniser.
- R8: When requests coincide, the watchdog wins over the internal request, and the internal request wins over the pin.
- R9: `flag_clr` clears all cause flags at the next edge. A cause recorded on the same edge takes precedence. `cause_flags` is always one-hot or zero.
- R10: `pin_drive` is 0 whenever `sys_rst` is 0. With the pin wired back from `pin_drive`, releasing an internally caused reset does not start another reset.
- R11: `rst_vec` equals RESET_VECTOR (default 16'h8000) at all times.
- R12: A new request during the release tail restarts the reset under the new cause, and the cause flags are updated to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| bo_low | input | 1 | Supply monitor output, 1 = supply below threshold (asynchronous clear) |
| wdt_req | input | 1 | Watchdog reset request, synchronous, level |
| sw_req | input | 1 | Internal software reset request, synchronous, level |
| pin_in | input | 1 | Sampled level of the bidirectional reset pin, active low, asynchronous |
| flag_clr | input | 1 | One-cycle strobe that clears the cause flags |
| sys_rst | output | 1 | System reset to the core, active high |
| pin_drive | output | 1 | Pull-low enable for the reset pin |
| cause_flags | output | 4 | One-hot cause: bit0 supply, bit1 watchdog, bit2 pin, bit3 internal |
| rst_vec | output | 16 | Restart address loaded by the core on release |

## Verification
The bench goes after exact edge counts. It checks that the start-up interval ends on its 1000th edge and not one sooner or later, that a brownout in mid-count restarts it, and that the release tail is exactly 16 edges. An off-by-one counter would release a cycle early or late and fail those samples. A single-cycle pin glitch must leave everything alone, since a filter that is too short would reset the core on noise. After an internal reset the pin is looped back from `pin_drive`; a design that does not mask its own pulse would re-enter reset forever. Coincident requests, a new request during the tail, and a flag clear on the same edge as a new cause each show a wrong priority as the wrong flag pattern.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   localparam int FLAG_W = 4;

   typedef enum logic [1:0] {
      ST_START = 2'd0,
      ST_RUN   = 2'd1,
      ST_ACT   = 2'd2,
      ST_HOLD  = 2'd3
   } rsq_state_e;

   // value equals the flag bit that records the cause
   typedef enum logic [1:0] {
      C_SUPPLY = 2'd0,
      C_WDT    = 2'd1,
      C_PIN    = 2'd2,
      C_SOFT   = 2'd3
   } rsq_cause_e;

   function automatic logic [FLAG_W-1:0] cause_flag(input rsq_cause_e c);
      return FLAG_W'(1) << c;
   endfunction

endpackage

// File: rtl/rsq_pin_sync.sv
module rsq_pin_sync #(
   parameter int STAGES  = 2,
   parameter int MIN_LOW = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic mask,
   input  logic pin_in,
   output logic ext_low,
   output logic ext_valid
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rsq_pin_sync: STAGES must be at least 2");
   end
   if (MIN_LOW < 1) begin : g_bad_min
      $error("rsq_pin_sync: MIN_LOW must be at least 1");
   end

   logic [STAGES-1:0] sync_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         sync_q <= '1;
      end else if (mask) begin
         sync_q <= '1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_in};
      end
   end

   assign ext_low = ~sync_q[STAGES-1];

   if (MIN_LOW > 1) begin : g_filter
      logic [MIN_LOW-2:0] hist_q;

      always_ff @(posedge clk or posedge arst) begin
         if (arst) begin
            hist_q <= '1;
         end else if (mask) begin
            hist_q <= '1;
         end else begin
            hist_q <= (MIN_LOW-1)'({hist_q, sync_q[STAGES-1]});
         end
      end

      assign ext_valid = ~|{hist_q, sync_q[STAGES-1]};
   end else begin : g_nofilter
      assign ext_valid = ext_low;
   end

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
   import rsq_pkg::*;
#(
   parameter int STARTUP_CYCLES = 1000,
   parameter int HOLD_CYCLES    = 16,
   parameter int CNT_W          = 10
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              wdt_req,
   input  logic              sw_req,
   input  logic              ext_valid,
   input  logic              ext_low,
   input  logic              flag_clr,
   output logic              sys_rst,
   output logic              pin_drive,
   output logic [FLAG_W-1:0] flags
);

   localparam logic [CNT_W-1:0] LAST_START = CNT_W'(STARTUP_CYCLES - 1);
   localparam logic [CNT_W-1:0] LAST_HOLD  = CNT_W'(HOLD_CYCLES - 1);

   rsq_state_e        state_q, state_n;
   rsq_cause_e        cause_q, cause_n, pick;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [FLAG_W-1:0] flags_q, flags_n;
   logic              drive_q, drive_n;
   logic              any_req, still_on;

   always_comb begin
      any_req = wdt_req | sw_req | ext_valid;
      if (wdt_req)     pick = C_WDT;
      else if (sw_req) pick = C_SOFT;
      else             pick = C_PIN;

      case (cause_q)
         C_WDT:   still_on = wdt_req;
         C_SOFT:  still_on = sw_req;
         C_PIN:   still_on = ext_low;
         default: still_on = 1'b0;
      endcase

      state_n = state_q;
      cause_n = cause_q;
      cnt_n   = cnt_q;
      flags_n = flag_clr ? '0 : flags_q;

      case (state_q)
         ST_START: begin
            if (cnt_q == LAST_START) begin
               state_n = ST_RUN;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         ST_RUN: begin
            if (any_req) begin
               state_n = ST_ACT;
               cause_n = pick;
               flags_n = cause_flag(pick);
            end
         end
         ST_ACT: begin
            if (!still_on) begin
               state_n = ST_HOLD;
               cnt_n   = CNT_W'(1);
            end
         end
         default: begin
            if (any_req) begin
               state_n = ST_ACT;
               cause_n = pick;
               flags_n = cause_flag(pick);
               cnt_n   = '0;
            end else if (cnt_q == LAST_HOLD) begin
               state_n = ST_RUN;
               cnt_n   = '0;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
      endcase

      drive_n = (state_n != ST_RUN) && (cause_n != C_PIN);
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         state_q <= ST_START;
         cause_q <= C_SUPPLY;
         cnt_q   <= '0;
         flags_q <= cause_flag(C_SUPPLY);
         drive_q <= 1'b1;
      end else begin
         state_q <= state_n;
         cause_q <= cause_n;
         cnt_q   <= cnt_n;
         flags_q <= flags_n;
         drive_q <= drive_n;
      end
   end

   assign sys_rst   = (state_q != ST_RUN);
   assign pin_drive = drive_q;
   assign flags     = flags_q;

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import rsq_pkg::*;
#(
   parameter int               STARTUP_CYCLES = 1000,
   parameter int               HOLD_CYCLES    = 16,
   parameter int               SYNC_STAGES    = 2,
   parameter int               MIN_LOW        = 2,
   parameter int               VEC_W          = 16,
   parameter logic [VEC_W-1:0] RESET_VECTOR   = 16'h8000
) (
   input  logic              clk,
   input  logic              bo_low,
   input  logic              wdt_req,
   input  logic              sw_req,
   input  logic              pin_in,
   input  logic              flag_clr,
   output logic              sys_rst,
   output logic              pin_drive,
   output logic [FLAG_W-1:0] cause_flags,
   output logic [VEC_W-1:0]  rst_vec
);

   localparam int CNT_MAX = (STARTUP_CYCLES > HOLD_CYCLES) ? STARTUP_CYCLES : HOLD_CYCLES;
   localparam int CNT_W   = (CNT_MAX > 2) ? $clog2(CNT_MAX) : 1;

   if (STARTUP_CYCLES < 1) begin : g_bad_start
      $error("rst_sequencer: STARTUP_CYCLES must be at least 1");
   end
   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("rst_sequencer: HOLD_CYCLES must be at least 2");
   end

   logic ext_low, ext_valid;

   rsq_pin_sync #(
      .STAGES  (SYNC_STAGES),
      .MIN_LOW (MIN_LOW)
   ) u_pin (
      .clk       (clk),
      .arst      (bo_low),
      .mask      (pin_drive),
      .pin_in    (pin_in),
      .ext_low   (ext_low),
      .ext_valid (ext_valid)
   );

   rsq_ctrl #(
      .STARTUP_CYCLES (STARTUP_CYCLES),
      .HOLD_CYCLES    (HOLD_CYCLES),
      .CNT_W          (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .arst      (bo_low),
      .wdt_req   (wdt_req),
      .sw_req    (sw_req),
      .ext_valid (ext_valid),
      .ext_low   (ext_low),
      .flag_clr  (flag_clr),
      .sys_rst   (sys_rst),
      .pin_drive (pin_drive),
      .flags     (cause_flags)
   );

   assign rst_vec = RESET_VECTOR;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
   parameter int STARTUP_CYCLES = 1000,
   parameter int HOLD_CYCLES    = 16
) (
   input logic       clk,
   input logic       bo_low,
   input logic       wdt_req,
   input logic       sw_req,
   input logic       sys_rst,
   input logic       pin_drive,
   input logic [3:0] cause_flags
);

   int unsigned rst_len;
   int unsigned since_bo;

   always_ff @(posedge clk or posedge bo_low) begin
      if (bo_low) begin
         rst_len  <= 0;
         since_bo <= 0;
      end else begin
         rst_len  <= !sys_rst ? 0 : (rst_len < 32'hFFFF ? rst_len + 1 : rst_len);
         since_bo <= (since_bo < 32'hFFFF) ? since_bo + 1 : since_bo;
      end
   end

   // R1
   always @(posedge clk) begin
      if (bo_low) begin
         supply_hold_chk: assert (sys_rst && pin_drive && cause_flags == 4'b0001);
      end
   end

   // R2
   startup_len_chk: assert property (@(posedge clk) disable iff (bo_low)
      $fell(sys_rst) |-> since_bo >= STARTUP_CYCLES);

   // R3
   wdt_entry_chk: assert property (@(posedge clk) disable iff (bo_low)
      (!sys_rst && wdt_req) |=> (sys_rst && pin_drive && cause_flags == 4'b0010));

   // R4
   soft_entry_chk: assert property (@(posedge clk) disable iff (bo_low)
      (!sys_rst && sw_req && !wdt_req) |=> (sys_rst && pin_drive && cause_flags == 4'b1000));

   // R5
   pin_no_drive_chk: assert property (@(posedge clk) disable iff (bo_low)
      (sys_rst && cause_flags == 4'b0100) |-> !pin_drive);

   // R7
   hold_min_chk: assert property (@(posedge clk) disable iff (bo_low)
      $fell(sys_rst) |-> rst_len >= HOLD_CYCLES);

   // R9
   flags_onehot_chk: assert property (@(posedge clk) disable iff (bo_low)
      $onehot0(cause_flags));

   // R10
   drive_in_reset_chk: assert property (@(posedge clk) disable iff (bo_low)
      !sys_rst |-> !pin_drive);

endmodule

bind rst_sequencer rsq_checker #(
   .STARTUP_CYCLES (STARTUP_CYCLES),
   .HOLD_CYCLES    (HOLD_CYCLES)
) u_rsq_chk (
   .clk         (clk),
   .bo_low      (bo_low),
   .wdt_req     (wdt_req),
   .sw_req      (sw_req),
   .sys_rst     (sys_rst),
   .pin_drive   (pin_drive),
   .cause_flags (cause_flags)
);

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;

   typedef struct {
      int       at;
      bit       rst;
      bit       drv;
      bit [3:0] flg;
      string    tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        bo_low;
   logic        wdt_req, sw_req, flag_clr, ext_hold;
   logic        pin_in;
   logic        sys_rst, pin_drive;
   logic [3:0]  cause_flags;
   logic [15:0] rst_vec;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   // open-drain pin: low when the block pulls it or the board holds it
   assign pin_in = ~(pin_drive | ext_hold);

   rst_sequencer dut (
      .clk         (clk),
      .bo_low      (bo_low),
      .wdt_req     (wdt_req),
      .sw_req      (sw_req),
      .pin_in      (pin_in),
      .flag_clr    (flag_clr),
      .sys_rst     (sys_rst),
      .pin_drive   (pin_drive),
      .cause_flags (cause_flags),
      .rst_vec     (rst_vec)
   );

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic expect_at(input int k, input bit r, input bit d, input bit [3:0] f,
                            input string tag);
      exp_t e;
      e.at  = cyc + k;
      e.rst = r;
      e.drv = d;
      e.flg = f;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare due items at the falling edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            checks++;
            if (sys_rst !== sb[i].rst || pin_drive !== sb[i].drv || cause_flags !== sb[i].flg) begin
               errors++;
               $display("FAIL %s cyc=%0d: rst/drv/flags = %b/%b/%b expected %b/%b/%b",
                        sb[i].tag, cyc, sys_rst, pin_drive, cause_flags,
                        sb[i].rst, sb[i].drv, sb[i].flg);
            end
            sb.delete(i);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, pending=%0d expected 0", sb.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wdt_req = 0; sw_req = 0; flag_clr = 0; ext_hold = 0;
      bo_low = 0;
      #1 bo_low = 1;
      tick(1);
      // R1: held while supply low
      expect_at(1, 1, 1, 4'b0001, "R1");
      tick(2);

      // R2: start-up restarts on a new brownout
      bo_low = 0;
      expect_at(500, 1, 1, 4'b0001, "R2");
      tick(500);
      bo_low = 1;
      expect_at(1, 1, 1, 4'b0001, "R1");
      tick(3);
      bo_low = 0;
      expect_at(999, 1, 1, 4'b0001, "R2");
      expect_at(1000, 0, 0, 4'b0001, "R2");
      tick(1002);

      // R11
      checks++;
      if (rst_vec !== 16'h8000) begin
         errors++;
         $display("FAIL R11: rst_vec=%h expected 8000", rst_vec);
      end

      // R3 watchdog, R7 tail, R10 no self-retrigger
      wdt_req = 1;
      expect_at(1, 1, 1, 4'b0010, "R3");
      tick(3);
      wdt_req = 0;
      expect_at(15, 1, 1, 4'b0010, "R7");
      expect_at(16, 0, 0, 4'b0010, "R7");
      expect_at(24, 0, 0, 4'b0010, "R10");
      tick(26);

      // R9 clear
      flag_clr = 1;
      expect_at(1, 0, 0, 4'b0000, "R9");
      tick(1);
      flag_clr = 0;
      tick(2);

      // R4 internal request
      sw_req = 1;
      expect_at(1, 1, 1, 4'b1000, "R4");
      tick(2);
      sw_req = 0;
      expect_at(16, 0, 0, 4'b1000, "R4");
      expect_at(22, 0, 0, 4'b1000, "R10");
      tick(24);

      // R8 priority
      wdt_req = 1; sw_req = 1;
      expect_at(1, 1, 1, 4'b0010, "R8");
      tick(2);
      wdt_req = 0; sw_req = 0;
      expect_at(17, 0, 0, 4'b0010, "R8");
      tick(20);

      // R12 retrigger in the tail
      wdt_req = 1;
      tick(3);
      wdt_req = 0; sw_req = 1;
      expect_at(2, 1, 1, 4'b1000, "R12");
      tick(4);
      sw_req = 0;
      expect_at(16, 0, 0, 4'b1000, "R12");
      tick(20);

      // R6 one-edge glitch on the pin
      ext_hold = 1;
      tick(1);
      ext_hold = 0;
      expect_at(6, 0, 0, 4'b1000, "R6");
      tick(8);

      // R5 pin reset, R7 release through the synchroniser
      ext_hold = 1;
      expect_at(3, 0, 0, 4'b1000, "R5");
      expect_at(4, 1, 0, 4'b0100, "R5");
      tick(10);
      ext_hold = 0;
      expect_at(17, 1, 0, 4'b0100, "R7");
      expect_at(18, 0, 0, 4'b0100, "R7");
      tick(22);

      // R9 new cause beats clear on the same edge
      wdt_req = 1; flag_clr = 1;
      expect_at(1, 1, 1, 4'b0010, "R9");
      tick(1);
      flag_clr = 0;
      tick(2);
      wdt_req = 0;
      expect_at(16, 0, 0, 4'b0010, "R9");
      tick(20);

      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d items unchecked expected 0", sb.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule